// File: doc/BRIEF.md
# Word-Granular Self-Invalidating L1 Controller

This block is the private first-level cache controller of one core that runs data-race-free code split into parallel phases. Lines are direct mapped and hold several words. The address tag and a region identifier are kept per line. A coherence state is kept per word: Invalid, Valid or Registered. Each word also has a touched flag. No state is ever transient, and the controller never receives invalidations. Stale copies are removed by the controller itself: when the core signals the end of a phase, a sweep walks the lines and drops every Valid word of a written region that the core did not read.

The core issues loads and stores one at a time. A load to an absent or Invalid word fetches the whole line from the shared L2. The fill is merged only into Invalid slots. A store needs no fetch. It makes the word Registered and sends the L2 a registration that carries the word address and data. The L2 later acknowledges each registration with a one-cycle pulse. The controller counts registrations that are still open, and the core may start the next phase only while `phase_ready` is high.

Top module: `word_si_l1`

## Requirements
- R1: After reset every line is empty, `req_ready` and `phase_ready` are high, and `rsp_valid`, `rd_req_valid`, `reg_req_valid` and `sweep_done` are low.
- R2: A load to a word that is absent or Invalid issues exactly one single-cycle `rd_req_valid`, with `rd_req_line` = `req_addr[ADDR_W-1:log2(WORDS_PER_LINE)]`. In the cycle after `fill_valid`, the load returns word w of `fill_data[w*DATA_W +: DATA_W]`, where w = `req_addr[log2(WORDS_PER_LINE)-1:0]`, and the word becomes Valid.
- R3: A load to a Valid or Registered word of a present line issues no read request and returns the cached data on `rsp_valid` one cycle after acceptance.
- R4: A store issues no read request. One cycle after acceptance it raises `rsp_valid` together with a single `reg_req_valid` that carries the word address and store data. The word becomes Registered, and later loads return the stored data without a fetch.
- R5: A fill is written only into word slots that are Invalid. Valid and Registered words already in the line keep their data.
- R6: A store or fill changes the state of no word except the words named in R4 and R5. Neighbouring words of the same line keep their state and their data.
- R7: At phase end, for each present line whose region id r has bit r of `phase_wmask` set, every Valid word that was not read in the phase becomes Invalid. The region id is latched from `req_region` when the line is allocated.
- R8: The sweep keeps Registered words, touched Valid words and all words of lines whose region bit is clear. It clears every touched flag.
- R9: The sweep handles one line per cycle. `sweep_done` pulses once, NUM_LINES+1 cycles after the `phase_end` pulse is accepted in idle. `req_ready` stays low in between.
- R10: `phase_ready` is high only when no registration awaits its `reg_ack` and no sweep is active or pending.
- R11: While MAX_OUTSTANDING registrations are open, stores stall (`req_ready` low for a store) and loads are still accepted.
- R12: An access whose tag differs from the tag of the line at its index replaces that line. A later access to the old address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address {tag, index, offset} |
| req_wdata | input | DATA_W | Store data |
| req_region | input | log2(NUM_REGIONS) | Region id recorded on line allocation |
| req_ready | output | 1 | Request accepted at this edge when high |
| rsp_valid | output | 1 | Load data or store completion |
| rsp_data | output | DATA_W | Load data (store data for stores) |
| rd_req_valid | output | 1 | Line read request to the L2 |
| rd_req_line | output | ADDR_W-log2(WORDS_PER_LINE) | Line address of the read |
| fill_valid | input | 1 | Fill data valid |
| fill_data | input | WORDS_PER_LINE*DATA_W | Fill line, word w in bits [w*DATA_W +: DATA_W] |
| reg_req_valid | output | 1 | Word registration to the L2 |
| reg_req_addr | output | ADDR_W | Registered word address |
| reg_req_data | output | DATA_W | Registered word data |
| reg_ack | input | 1 | One registration acknowledged |
| phase_end | input | 1 | End-of-phase pulse |
| phase_wmask | input | NUM_REGIONS | Bit r set: region r was written in the phase |
| sweep_done | output | 1 | Sweep finished pulse |
| phase_ready | output | 1 | Next phase may begin |

## Verification
The controller is driven with directed sequences and with a long seeded random mix of loads and stores. The random mix uses four tags folded onto eight indices, so hits, partial-line merges and tag replacements interleave. Between phases the bench rewrites L2 words as another core would. Each load result is then compared with a bench model, which shows apart a correct sweep, a sweep that drops too much (the load fetches again and the fetch count differs) and a sweep that drops too little (the old value comes back). Directed cases pin the merge that skips Registered slots, the timing and stalls of the sweep, the second sweep that drops words once their touched flags are cleared, and the stall when the registration count is full while loads still pass.

// File: rtl/l1w_pkg.sv
package l1w_pkg;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_FETCH = 2'd1,
        FSM_SWEEP = 2'd2
    } fsm_e;

    localparam logic [1:0] WS_INV = 2'd0;
    localparam logic [1:0] WS_VAL = 2'd1;
    localparam logic [1:0] WS_REG = 2'd2;

endpackage

// File: rtl/l1w_reg_tracker.sv
module l1w_reg_tracker #(
    parameter int MAX_OUT = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue,
    input  logic                         ack,
    output logic [$clog2(MAX_OUT+1)-1:0] count,
    output logic                         full
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue && !ack) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!issue && ack) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(MAX_OUT));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !issue); // R11

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cnt_q != '0)); // R10

endmodule

// File: rtl/l1w_line_store.sv
module l1w_line_store #(
    parameter int NUM_LINES = 8,
    parameter int WORDS     = 4,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 5,
    parameter int RGN_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(NUM_LINES)-1:0]   idx,
    input  logic                           wr_en,
    input  logic                           wr_vld,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [RGN_W-1:0]               wr_rgn,
    input  logic [2*WORDS-1:0]             wr_st,
    input  logic [WORDS-1:0]               wr_tch,
    input  logic [WORDS*DATA_W-1:0]        wr_dat,
    output logic                           rd_vld,
    output logic [TAG_W-1:0]               rd_tag,
    output logic [RGN_W-1:0]               rd_rgn,
    output logic [2*WORDS-1:0]             rd_st,
    output logic [WORDS-1:0]               rd_tch,
    output logic [WORDS*DATA_W-1:0]        rd_dat
);
    localparam int IDX_W = $clog2(NUM_LINES);

    logic                    vld_a [NUM_LINES];
    logic [TAG_W-1:0]        tag_a [NUM_LINES];
    logic [RGN_W-1:0]        rgn_a [NUM_LINES];
    logic [2*WORDS-1:0]      st_a  [NUM_LINES];
    logic [WORDS-1:0]        tch_a [NUM_LINES];
    logic [WORDS*DATA_W-1:0] dat_a [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic                    vld_q;
        logic [TAG_W-1:0]        tag_q;
        logic [RGN_W-1:0]        rgn_q;
        logic [2*WORDS-1:0]      st_q;
        logic [WORDS-1:0]        tch_q;
        logic [WORDS*DATA_W-1:0] dat_q;
        logic                    sel;

        assign sel = wr_en && (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                st_q  <= '0;
                tch_q <= '0;
            end else if (sel) begin
                vld_q <= wr_vld;
                st_q  <= wr_st;
                tch_q <= wr_tch;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q <= wr_tag;
                rgn_q <= wr_rgn;
                dat_q <= wr_dat;
            end
        end

        assign vld_a[i] = vld_q;
        assign tag_a[i] = tag_q;
        assign rgn_a[i] = rgn_q;
        assign st_a[i]  = st_q;
        assign tch_a[i] = tch_q;
        assign dat_a[i] = dat_q;
    end

    assign rd_vld = vld_a[idx];
    assign rd_tag = tag_a[idx];
    assign rd_rgn = rgn_a[idx];
    assign rd_st  = st_a[idx];
    assign rd_tch = tch_a[idx];
    assign rd_dat = dat_a[idx];

endmodule

// File: rtl/word_si_l1.sv
module word_si_l1
    import l1w_pkg::*;
#(
    parameter int NUM_LINES       = 8,
    parameter int WORDS_PER_LINE  = 4,
    parameter int DATA_W          = 32,
    parameter int ADDR_W          = 10,
    parameter int NUM_REGIONS     = 4,
    parameter int MAX_OUTSTANDING = 15
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    input  logic                                        req_write,
    input  logic [ADDR_W-1:0]                           req_addr,
    input  logic [DATA_W-1:0]                           req_wdata,
    input  logic [$clog2(NUM_REGIONS)-1:0]              req_region,
    output logic                                        req_ready,
    output logic                                        rsp_valid,
    output logic [DATA_W-1:0]                           rsp_data,
    output logic                                        rd_req_valid,
    output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0]    rd_req_line,
    input  logic                                        fill_valid,
    input  logic [WORDS_PER_LINE*DATA_W-1:0]            fill_data,
    output logic                                        reg_req_valid,
    output logic [ADDR_W-1:0]                           reg_req_addr,
    output logic [DATA_W-1:0]                           reg_req_data,
    input  logic                                        reg_ack,
    input  logic                                        phase_end,
    input  logic [NUM_REGIONS-1:0]                      phase_wmask,
    output logic                                        sweep_done,
    output logic                                        phase_ready
);
    localparam int OFF_W   = $clog2(WORDS_PER_LINE);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int RGN_W   = $clog2(NUM_REGIONS);
    localparam int CNT_W   = $clog2(MAX_OUTSTANDING + 1);
    localparam int W       = WORDS_PER_LINE;

    typedef struct packed {
        fsm_e                 fsm;
        logic [ADDR_W-1:0]    addr;
        logic [RGN_W-1:0]     rgn;
        logic [IDX_W-1:0]     sidx;
        logic                 pend;
        logic [NUM_REGIONS-1:0] pmask;
        logic                 rsp_v;
        logic [DATA_W-1:0]    rsp_d;
        logic                 rdq_v;
        logic [LADDR_W-1:0]   rdq_line;
        logic                 regq_v;
        logic [ADDR_W-1:0]    regq_addr;
        logic [DATA_W-1:0]    regq_data;
        logic                 done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields of the incoming request and the held miss
    logic [OFF_W-1:0] req_off, miss_off;
    logic [IDX_W-1:0] req_idx, miss_idx, ln_idx;
    logic [TAG_W-1:0] req_tag, miss_tag;

    assign req_off  = req_addr[OFF_W-1:0];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign miss_off = ctl_q.addr[OFF_W-1:0];
    assign miss_idx = ctl_q.addr[OFF_W +: IDX_W];
    assign miss_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        unique case (ctl_q.fsm)
            FSM_FETCH: ln_idx = miss_idx;
            FSM_SWEEP: ln_idx = ctl_q.sidx;
            default:   ln_idx = req_idx;
        endcase
    end

    // line store port
    logic                 rd_vld, wr_en, wr_vld;
    logic [TAG_W-1:0]     rd_tag, wr_tag;
    logic [RGN_W-1:0]     rd_rgn, wr_rgn;
    logic [2*W-1:0]       rd_st, wr_st;
    logic [W-1:0]         rd_tch, wr_tch;
    logic [W*DATA_W-1:0]  rd_dat, wr_dat;

    l1w_line_store #(
        .NUM_LINES (NUM_LINES),
        .WORDS     (W),
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .RGN_W     (RGN_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (ln_idx),
        .wr_en  (wr_en),
        .wr_vld (wr_vld),
        .wr_tag (wr_tag),
        .wr_rgn (wr_rgn),
        .wr_st  (wr_st),
        .wr_tch (wr_tch),
        .wr_dat (wr_dat),
        .rd_vld (rd_vld),
        .rd_tag (rd_tag),
        .rd_rgn (rd_rgn),
        .rd_st  (rd_st),
        .rd_tch (rd_tch),
        .rd_dat (rd_dat)
    );

    // open registration count
    logic             issue, full;
    logic [CNT_W-1:0] open_cnt;

    l1w_reg_tracker #(
        .MAX_OUT (MAX_OUTSTANDING)
    ) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .ack   (reg_ack),
        .count (open_cnt),
        .full  (full)
    );

    logic       ready_c, hit_line, word_live;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rsp_v  = 1'b0;
        ctl_d.rdq_v  = 1'b0;
        ctl_d.regq_v = 1'b0;
        ctl_d.done   = 1'b0;
        ready_c      = 1'b0;
        issue        = 1'b0;
        hit_line     = 1'b0;
        word_live    = 1'b0;
        wr_en        = 1'b0;
        wr_vld       = rd_vld;
        wr_tag       = rd_tag;
        wr_rgn       = rd_rgn;
        wr_st        = rd_st;
        wr_tch       = rd_tch;
        wr_dat       = rd_dat;

        if (phase_end && ctl_q.fsm != FSM_IDLE) begin
            ctl_d.pend  = 1'b1;
            ctl_d.pmask = phase_wmask;
        end

        unique case (ctl_q.fsm)
            FSM_IDLE: begin
                hit_line = rd_vld && (rd_tag == req_tag);
                for (int w = 0; w < W; w++) begin
                    if (OFF_W'(w) == req_off) begin
                        word_live = (rd_st[2*w +: 2] != WS_INV);
                    end
                end
                if (phase_end || ctl_q.pend) begin
                    ctl_d.fsm   = FSM_SWEEP;
                    ctl_d.sidx  = '0;
                    ctl_d.pmask = phase_end ? phase_wmask : ctl_q.pmask;
                    ctl_d.pend  = 1'b0;
                end else begin
                    ready_c = !(req_write && full);
                    if (req_valid && ready_c) begin
                        if (req_write) begin
                            wr_en = 1'b1;
                            issue = 1'b1;
                            if (!hit_line) begin
                                wr_vld = 1'b1;
                                wr_tag = req_tag;
                                wr_rgn = req_region;
                                wr_st  = '0;
                                wr_tch = '0;
                            end
                            for (int w = 0; w < W; w++) begin
                                if (OFF_W'(w) == req_off) begin
                                    wr_st[2*w +: 2]           = WS_REG;
                                    wr_dat[w*DATA_W +: DATA_W] = req_wdata;
                                end
                            end
                            ctl_d.rsp_v     = 1'b1;
                            ctl_d.rsp_d     = req_wdata;
                            ctl_d.regq_v    = 1'b1;
                            ctl_d.regq_addr = req_addr;
                            ctl_d.regq_data = req_wdata;
                        end else if (hit_line && word_live) begin
                            wr_en = 1'b1;
                            for (int w = 0; w < W; w++) begin
                                if (OFF_W'(w) == req_off) begin
                                    wr_tch[w]   = 1'b1;
                                    ctl_d.rsp_d = rd_dat[w*DATA_W +: DATA_W];
                                end
                            end
                            ctl_d.rsp_v = 1'b1;
                        end else begin
                            ctl_d.fsm      = FSM_FETCH;
                            ctl_d.addr     = req_addr;
                            ctl_d.rgn      = req_region;
                            ctl_d.rdq_v    = 1'b1;
                            ctl_d.rdq_line = req_addr[ADDR_W-1:OFF_W];
                        end
                    end
                end
            end

            FSM_FETCH: begin
                hit_line = rd_vld && (rd_tag == miss_tag);
                if (fill_valid) begin
                    wr_en = 1'b1;
                    if (!hit_line) begin
                        wr_vld = 1'b1;
                        wr_tag = miss_tag;
                        wr_rgn = ctl_q.rgn;
                        wr_st  = '0;
                        wr_tch = '0;
                    end
                    for (int w = 0; w < W; w++) begin
                        if (wr_st[2*w +: 2] == WS_INV) begin
                            wr_st[2*w +: 2]            = WS_VAL;
                            wr_dat[w*DATA_W +: DATA_W] = fill_data[w*DATA_W +: DATA_W];
                        end
                    end
                    for (int w = 0; w < W; w++) begin
                        if (OFF_W'(w) == miss_off) begin
                            wr_tch[w]   = 1'b1;
                            ctl_d.rsp_d = wr_dat[w*DATA_W +: DATA_W];
                        end
                    end
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.fsm   = FSM_IDLE;
                end
            end

            FSM_SWEEP: begin
                wr_en = 1'b1;
                for (int w = 0; w < W; w++) begin
                    if (rd_vld && ctl_q.pmask[rd_rgn] &&
                        rd_st[2*w +: 2] == WS_VAL && !rd_tch[w]) begin
                        wr_st[2*w +: 2] = WS_INV;
                    end
                end
                wr_tch = '0;
                if (ctl_q.sidx == IDX_W'(NUM_LINES - 1)) begin
                    ctl_d.fsm  = FSM_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.sidx = ctl_q.sidx + 1'b1;
                end
            end

            default: ctl_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready     = ready_c;
    assign rsp_valid     = ctl_q.rsp_v;
    assign rsp_data      = ctl_q.rsp_d;
    assign rd_req_valid  = ctl_q.rdq_v;
    assign rd_req_line   = ctl_q.rdq_line;
    assign reg_req_valid = ctl_q.regq_v;
    assign reg_req_addr  = ctl_q.regq_addr;
    assign reg_req_data  = ctl_q.regq_data;
    assign sweep_done    = ctl_q.done;
    assign phase_ready   = (open_cnt == '0) && (ctl_q.fsm != FSM_SWEEP) && !ctl_q.pend;

    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid); // R2

    AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == FSM_FETCH && fill_valid) |=> (rsp_valid && !rd_req_valid)); // R2

    AST_REG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_valid |-> rsp_valid); // R4

    AST_SWEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == FSM_SWEEP) |=> !rsp_valid); // R9

    AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (ctl_q.fsm == FSM_IDLE && $past(ctl_q.fsm) == FSM_SWEEP)); // R9

endmodule

// File: tb/word_si_l1_bench.sv
module word_si_l1_bench;
    localparam int NL   = 8;
    localparam int WPL  = 4;
    localparam int DW   = 32;
    localparam int AW   = 10;
    localparam int NR   = 4;
    localparam int MAXO = 15;
    localparam int RW   = 2;
    localparam int LW   = AW - 2;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [RW-1:0] req_region;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_data;
    logic rd_req_valid;
    logic [LW-1:0] rd_req_line;
    logic fill_valid;
    logic [WPL*DW-1:0] fill_data;
    logic reg_req_valid;
    logic [AW-1:0] reg_req_addr;
    logic [DW-1:0] reg_req_data;
    logic reg_ack;
    logic phase_end;
    logic [NR-1:0] phase_wmask;
    logic sweep_done, phase_ready;

    always #10 clk = ~clk;

    word_si_l1 u_word_si_l1 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_region(req_region), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rd_req_valid(rd_req_valid), .rd_req_line(rd_req_line),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .reg_req_valid(reg_req_valid), .reg_req_addr(reg_req_addr),
        .reg_req_data(reg_req_data), .reg_ack(reg_ack),
        .phase_end(phase_end), .phase_wmask(phase_wmask),
        .sweep_done(sweep_done), .phase_ready(phase_ready)
    );

    int checks = 0;
    int errors = 0;

    // L2 image and bench model of the cache
    logic [DW-1:0] l2mem [1024];
    bit            m_vld [NL];
    int            m_tag [NL];
    int            m_rgn [NL];
    int            m_st  [NL][WPL];   // 0 invalid, 1 valid, 2 registered
    bit            m_tch [NL][WPL];
    logic [DW-1:0] m_dat [NL][WPL];

    int n_rd = 0, n_reg = 0, owed = 0;
    bit hold_acks = 0;
    logic [AW-1:0] last_reg_addr;
    logic [DW-1:0] last_reg_data;

    task automatic check(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
        return AW'(tag * 32 + idx * 4 + off);
    endfunction

    // L2 read side
    initial begin
        fill_valid = 0;
        fill_data  = '0;
        forever begin
            @(negedge clk);
            if (rd_req_valid) begin
                automatic logic [LW-1:0] ln = rd_req_line;
                n_rd++;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                for (int w = 0; w < WPL; w++) fill_data[w*DW +: DW] = l2mem[{ln, 2'(w)}];
                fill_valid = 1;
                @(negedge clk);
                fill_valid = 0;
            end
        end
    end

    // L2 registration side
    initial begin
        reg_ack = 0;
        forever begin
            @(negedge clk);
            if (reg_req_valid) begin
                l2mem[reg_req_addr] = reg_req_data;
                last_reg_addr = reg_req_addr;
                last_reg_data = reg_req_data;
                n_reg++;
                owed++;
            end
            reg_ack = 0;
            if (!hold_acks && owed > 0 && $urandom_range(0, 2) == 0) begin
                reg_ack = 1;
                owed--;
            end
        end
    end

    task automatic m_load(input logic [AW-1:0] a, input int rg, output logic [DW-1:0] exp, output int miss);
        int tag = int'(a[9:5]);
        int idx = int'(a[4:2]);
        int off = int'(a[1:0]);
        if (m_vld[idx] && m_tag[idx] == tag && m_st[idx][off] != 0) begin
            miss = 0;
        end else begin
            miss = 1;
            if (!(m_vld[idx] && m_tag[idx] == tag)) begin
                m_vld[idx] = 1; m_tag[idx] = tag; m_rgn[idx] = rg;
                for (int w = 0; w < WPL; w++) begin m_st[idx][w] = 0; m_tch[idx][w] = 0; end
            end
            for (int w = 0; w < WPL; w++) begin
                if (m_st[idx][w] == 0) begin
                    m_st[idx][w] = 1;
                    m_dat[idx][w] = l2mem[{a[9:2], 2'(w)}];
                end
            end
        end
        m_tch[idx][off] = 1;
        exp = m_dat[idx][off];
    endtask

    task automatic m_store(input logic [AW-1:0] a, input logic [DW-1:0] wd, input int rg);
        int tag = int'(a[9:5]);
        int idx = int'(a[4:2]);
        int off = int'(a[1:0]);
        if (!(m_vld[idx] && m_tag[idx] == tag)) begin
            m_vld[idx] = 1; m_tag[idx] = tag; m_rgn[idx] = rg;
            for (int w = 0; w < WPL; w++) begin m_st[idx][w] = 0; m_tch[idx][w] = 0; end
        end
        m_st[idx][off] = 2;
        m_dat[idx][off] = wd;
    endtask

    task automatic m_sweep(input logic [NR-1:0] mask);
        for (int i = 0; i < NL; i++) begin
            for (int w = 0; w < WPL; w++) begin
                if (m_vld[i] && mask[m_rgn[i]] && m_st[i][w] == 1 && !m_tch[i][w]) m_st[i][w] = 0;
                m_tch[i][w] = 0;
            end
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int rg, output logic [DW-1:0] rd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_region = RW'(rg);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_data;
        #1;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input int rg, input string r);
        logic [DW-1:0] exp, got;
        int miss;
        int n0 = n_rd;
        m_load(a, rg, exp, miss);
        access(0, a, '0, rg, got);
        check(got == exp, {r, " load data"}, got, exp);
        check((n_rd - n0) == miss, {r, " fetch count"}, DW'(n_rd - n0), DW'(miss));
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] wd, input int rg, input string r);
        logic [DW-1:0] got;
        int n0 = n_rd;
        int g0 = n_reg;
        m_store(a, wd, rg);
        access(1, a, wd, rg, got);
        check((n_reg - g0) == 1 && last_reg_addr == a && last_reg_data == wd,
              {r, " registration"}, DW'(last_reg_addr), DW'(a));
        check(n_rd == n0, {r, " no fetch on store"}, DW'(n_rd - n0), 0);
    endtask

    task automatic do_phase(input logic [NR-1:0] mask, input string r);
        int cnt = 0;
        bit stalled = 1;
        @(negedge clk);
        phase_end = 1; phase_wmask = mask;
        @(negedge clk);
        phase_end = 0;
        cnt = 1;
        while (!sweep_done && cnt < 100) begin
            if (req_ready) stalled = 0;
            @(negedge clk);
            cnt++;
        end
        check(cnt == NL + 1, {r, " R9 sweep_done timing"}, DW'(cnt), DW'(NL + 1));
        check(stalled, {r, " R9 req_ready low in sweep"}, DW'(stalled), 1);
        m_sweep(mask);
    endtask

    task automatic drain_acks();
        hold_acks = 0;
        while (owed != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] junk;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) l2mem[i] = DW'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
        for (int i = 0; i < NL; i++) m_vld[i] = 0;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        req_region = '0; phase_end = 0; phase_wmask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(req_ready == 1, "R1 req_ready", DW'(req_ready), 1);
        check(phase_ready == 1, "R1 phase_ready", DW'(phase_ready), 1);
        check(!rsp_valid && !rd_req_valid && !reg_req_valid && !sweep_done, "R1 outputs idle",
              DW'({rsp_valid, rd_req_valid, reg_req_valid, sweep_done}), 0);
        do_load(mk(1, 0, 2), 0, "R1 R2 first load misses");
        // R3 hits
        do_load(mk(1, 0, 2), 0, "R3 repeat load hits");
        do_load(mk(1, 0, 0), 0, "R3 neighbour valid after fill");
        // R4 and R6
        do_store(mk(1, 0, 1), 32'hCAFE_0001, 0, "R4 store");
        do_load(mk(1, 0, 1), 0, "R4 load returns stored data");
        do_load(mk(1, 0, 3), 0, "R6 neighbour keeps valid state");
        // R5 merge skips registered slot
        do_store(mk(2, 2, 0), 32'hBEEF_0002, 1, "R5 store allocates line");
        drain_acks();
        l2mem[mk(2, 2, 0)] = 32'h1111_2222;
        do_load(mk(2, 2, 1), 1, "R5 fill into invalid slot");
        do_load(mk(2, 2, 0), 1, "R5 registered word kept");
        // R12 replacement
        do_load(mk(0, 3, 0), 2, "R12 first tag");
        do_load(mk(3, 3, 0), 2, "R12 other tag evicts");
        do_load(mk(0, 3, 0), 2, "R12 old tag misses");
        // R7 R8 sweep
        do_load(mk(0, 4, 0), 1, "R7 setup line region 1");
        do_store(mk(0, 4, 2), 32'h0000_AAAA, 1, "R8 setup registered word");
        do_load(mk(0, 5, 0), 2, "R8 setup line region 2");
        drain_acks();
        for (int w = 0; w < WPL; w++) begin
            l2mem[mk(0, 4, w)] = l2mem[mk(0, 4, w)] + 32'h100;
            l2mem[mk(0, 5, w)] = l2mem[mk(0, 5, w)] + 32'h100;
        end
        do_phase(4'b0010, "R7");
        do_load(mk(0, 4, 1), 1, "R7 untouched valid word dropped");
        do_load(mk(0, 4, 0), 1, "R8 touched word kept");
        do_load(mk(0, 4, 2), 1, "R8 registered word kept");
        do_load(mk(0, 5, 1), 2, "R8 unmasked region kept");
        do_phase(4'b0000, "R8 clear touched");
        l2mem[mk(0, 4, 3)] = 32'h7777_0000;
        do_phase(4'b0010, "R8 second sweep");
        do_load(mk(0, 4, 3), 1, "R8 touched flag cleared then dropped");
        // R10
        drain_acks();
        hold_acks = 1;
        do_store(mk(1, 6, 0), 32'h0000_1234, 3, "R10 store");
        check(phase_ready == 0, "R10 phase_ready low with open registration", DW'(phase_ready), 0);
        drain_acks();
        check(phase_ready == 1, "R10 phase_ready high after acks", DW'(phase_ready), 1);
        // R11
        hold_acks = 1;
        for (int k = 0; k < MAXO; k++) do_store(mk(1, 7, k % 4), DW'(k), 0, "R11 fill count");
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = mk(1, 7, 0); req_wdata = '0; req_region = '0;
        #1;
        check(req_ready == 0, "R11 store stalls when full", DW'(req_ready), 0);
        req_write = 0;
        #1;
        check(req_ready == 1, "R11 load accepted when full", DW'(req_ready), 1);
        req_valid = 0;
        drain_acks();
        do_store(mk(1, 7, 0), 32'h0F0F_0F0F, 0, "R11 store after drain");
        // random phases
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 60; k++) begin
                automatic logic [AW-1:0] a = mk($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3));
                automatic int rg = $urandom_range(0, NR - 1);
                if ($urandom_range(0, 9) < 7) do_load(a, rg, "R2 R3 R12 random load");
                else do_store(a, $urandom, rg, "R4 random store");
            end
            drain_acks();
            for (int k = 0; k < 20; k++) l2mem[$urandom_range(0, 127)] = $urandom;
            do_phase(NR'($urandom), "R7 random");
        end
        junk = '0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule